// File: doc/BRIEF.md
# Serial-Load Cartridge Bank Controller

This block translates addresses for a cartridge that holds more program and character ROM than the host processor and the picture processor can see at once. Software programs it by writing to the upper half of the CPU address space. Each write carries a single data bit, and five such writes assemble one 5-bit value in a shift loader. The CPU address of the fifth write chooses which of four internal registers receives that value: control, character bank 0, character bank 1 or program bank. A write with data bit 7 set abandons a partial value and returns the program layout to its power-up form.

From those registers the block derives two 16 KB program windows, two 4 KB character windows and a nametable mirroring mode, and holds them in a registered window stage. Using that stage, it maps every CPU address to a program ROM offset, every picture-processor address to a character ROM offset, and every nametable address to an offset into 2 KB of nametable RAM. The ROM and RAM arrays sit outside the block. The number of program banks on the cartridge is an input, and it sets which bank counts as the last one.

Top module: `serial_bank_mapper`

## Requirements
- R1: After reset the shift loader is empty with a count of 5. The control register holds 0x0C, and the two character bank registers and the program bank register hold 0. One clock later the windows show program low 0, program high `prg_bank_count`-1, character low 0, character high 1 and mirroring mode 0.
- R2: A write has no effect when `wr_en` is low or `cpu_addr[15]` is 0. The shift loader and all registers stay as they were.
- R3: A write in the upper half with `wr_data[7]`=1 empties the loader and sets the count back to 5. It sets control bits 3:2 to 11 and leaves control bits 4 and 1:0 unchanged.
- R4: Any other upper-half write shifts the loader right, with `wr_data[0]` entering bit 4, so the first write supplies bit 0 of the value. The fifth write commits the value and empties the loader. `cpu_addr[14:13]` of that write picks the target: 0 control, 1 character bank 0, 2 character bank 1, 3 program bank.
- R5: The window outputs (`prg_bank_*`, `chr_bank_*`, `mirror_mode`) reflect a committed value one clock edge after the commit edge, not on the commit edge itself.
- R6: `mirror_mode` equals control bits 1:0. `nt_offset` is {0, `ppu_addr[9:0]`} for mode 0 and {1, `ppu_addr[9:0]`} for mode 1. It is `ppu_addr[10:0]` for mode 2 and {`ppu_addr[11]`, `ppu_addr[9:0]`} for mode 3.
- R7: When control bit 4 is 0, the character windows are bank0 with bit 0 cleared and bank0 with bit 0 set. When control bit 4 is 1, they are bank0 and bank1 unchanged.
- R8: Control bits 3:2 select the program layout. Value 2 gives low=0 and high=program bank. Value 3 gives low=program bank and high=`prg_bank_count`-1. Values 0 and 1 give low=program bank with bit 0 cleared and high=program bank with bit 0 set.
- R9: `rom_offset` is {window selected by `cpu_addr[14]` (0 low, 1 high), `cpu_addr[13:0]`}.
- R10: `chr_offset` is {window selected by `ppu_addr[12]` (0 low, 1 high), `ppu_addr[11:0]`}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address, used for writes and for program translation |
| wr_data | input | 8 | CPU write data; bit 7 resets the loader and bit 0 is the serial bit |
| prg_bank_count | input | SHIFT_W+1 | Number of 16 KB program banks on the cartridge (at least 1) |
| ppu_addr | input | 14 | Picture-processor address for character and nametable translation |
| prg_bank_lo | output | SHIFT_W | Program bank mapped at CPU 0x8000-0xBFFF |
| prg_bank_hi | output | SHIFT_W | Program bank mapped at CPU 0xC000-0xFFFF |
| chr_bank_lo | output | SHIFT_W | Character bank for the low 4 KB window |
| chr_bank_hi | output | SHIFT_W | Character bank for the high 4 KB window |
| mirror_mode | output | 2 | Nametable mirroring mode |
| rom_offset | output | SHIFT_W+14 | Program ROM byte offset for `cpu_addr` |
| chr_offset | output | SHIFT_W+12 | Character ROM byte offset for `ppu_addr` |
| nt_offset | output | 11 | Nametable RAM offset for `ppu_addr` |

## Verification
The assertions check on every cycle the rules that hold at all times. A loader reset always yields a full count and layout 3. Ignored writes leave the count and the control register unchanged. Under the pairing layouts the program and character windows are always an even/odd pair, layout 2 always pins the low program window to 0, and the low bits of both ROM offsets always pass the address through. Only the bench scenarios can show the serial ordering of the assembled value, the choice of target register, the one-edge delay before the windows move, the fixed last bank, and the nametable mapping of each mirroring mode, because each of these needs a whole sequence of writes and a known expected value.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

    typedef enum logic [1:0] {
        MIR_ONE_LOW  = 2'd0,
        MIR_ONE_HIGH = 2'd1,
        MIR_VERT     = 2'd2,
        MIR_HORZ     = 2'd3
    } mirror_e;

    typedef enum logic [1:0] {
        PRG_PAIR_A   = 2'd0,
        PRG_PAIR_B   = 2'd1,
        PRG_FIX_LOW  = 2'd2,
        PRG_FIX_HIGH = 2'd3
    } prg_layout_e;

    typedef enum logic [1:0] {
        TGT_CTRL = 2'd0,
        TGT_CHR0 = 2'd1,
        TGT_CHR1 = 2'd2,
        TGT_PRG  = 2'd3
    } target_e;

    // Control register field positions
    localparam int CTRL_CHR_SPLIT = 4;
    localparam int CTRL_LAYOUT_HI = 3;
    localparam int CTRL_LAYOUT_LO = 2;

    // Fixed address geometry
    localparam int PRG_PAGE_W = 14;
    localparam int CHR_PAGE_W = 12;
    localparam int NT_OFF_W   = 11;
    localparam int CPU_AW     = 16;
    localparam int PPU_AW     = 14;

endpackage

// File: rtl/mapper_serial_loader.sv
module mapper_serial_loader #(
    parameter int SHIFT_W = 5,
    localparam int CNT_W  = $clog2(SHIFT_W + 1)
) (
    input  logic               wr_fire,
    input  logic               reset_bit,
    input  logic               data_bit,
    input  logic [SHIFT_W-1:0] shift_q,
    input  logic [CNT_W-1:0]   count_q,
    output logic [SHIFT_W-1:0] shift_d,
    output logic [CNT_W-1:0]   count_d,
    output logic               commit,
    output logic               loader_reset,
    output logic [SHIFT_W-1:0] commit_val
);
    localparam logic [CNT_W-1:0] FULL_COUNT = CNT_W'(SHIFT_W);

    logic [SHIFT_W-1:0] shifted;

    always_comb begin
        shifted      = {data_bit, shift_q[SHIFT_W-1:1]};
        shift_d      = shift_q;
        count_d      = count_q;
        commit       = 1'b0;
        loader_reset = 1'b0;
        commit_val   = shifted;
        if (wr_fire) begin
            if (reset_bit) begin
                shift_d      = '0;
                count_d      = FULL_COUNT;
                loader_reset = 1'b1;
            end else if (count_q == CNT_W'(1)) begin
                shift_d = '0;
                count_d = FULL_COUNT;
                commit  = 1'b1;
            end else begin
                shift_d = shifted;
                count_d = count_q - CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/mapper_bank_calc.sv
module mapper_bank_calc
    import mapper_pkg::*;
#(
    parameter int SHIFT_W = 5
) (
    input  logic [SHIFT_W-1:0] ctrl,
    input  logic [SHIFT_W-1:0] chr0,
    input  logic [SHIFT_W-1:0] chr1,
    input  logic [SHIFT_W-1:0] prg,
    input  logic [SHIFT_W-1:0] last_bank,
    output logic [SHIFT_W-1:0] prg_lo,
    output logic [SHIFT_W-1:0] prg_hi,
    output logic [SHIFT_W-1:0] chr_lo,
    output logic [SHIFT_W-1:0] chr_hi,
    output mirror_e            mirror
);
    localparam logic [SHIFT_W-1:0] ODD_BIT = SHIFT_W'(1);

    prg_layout_e layout;

    always_comb begin
        mirror = mirror_e'(ctrl[1:0]);
        layout = prg_layout_e'(ctrl[CTRL_LAYOUT_HI:CTRL_LAYOUT_LO]);

        if (ctrl[CTRL_CHR_SPLIT]) begin
            chr_lo = chr0;
            chr_hi = chr1;
        end else begin
            chr_lo = chr0 & ~ODD_BIT;
            chr_hi = chr0 | ODD_BIT;
        end

        unique case (layout)
            PRG_FIX_LOW: begin
                prg_lo = '0;
                prg_hi = prg;
            end
            PRG_FIX_HIGH: begin
                prg_lo = prg;
                prg_hi = last_bank;
            end
            default: begin
                prg_lo = prg & ~ODD_BIT;
                prg_hi = prg | ODD_BIT;
            end
        endcase
    end

endmodule

// File: rtl/mapper_addr_xlate.sv
module mapper_addr_xlate
    import mapper_pkg::*;
#(
    parameter int SHIFT_W     = 5,
    localparam int ROM_OFF_W  = SHIFT_W + PRG_PAGE_W,
    localparam int CHR_OFF_W  = SHIFT_W + CHR_PAGE_W
) (
    input  logic [PRG_PAGE_W:0]   cpu_low,
    input  logic [PPU_AW-2:0]     ppu_low,
    input  logic [SHIFT_W-1:0]    prg_lo,
    input  logic [SHIFT_W-1:0]    prg_hi,
    input  logic [SHIFT_W-1:0]    chr_lo,
    input  logic [SHIFT_W-1:0]    chr_hi,
    input  mirror_e               mirror,
    output logic [ROM_OFF_W-1:0]  rom_offset,
    output logic [CHR_OFF_W-1:0]  chr_offset,
    output logic [NT_OFF_W-1:0]   nt_offset
);
    logic [SHIFT_W-1:0] prg_sel;
    logic [SHIFT_W-1:0] chr_sel;
    logic               nt_page;

    always_comb begin
        prg_sel    = cpu_low[PRG_PAGE_W] ? prg_hi : prg_lo;
        rom_offset = {prg_sel, cpu_low[PRG_PAGE_W-1:0]};

        chr_sel    = ppu_low[CHR_PAGE_W] ? chr_hi : chr_lo;
        chr_offset = {chr_sel, ppu_low[CHR_PAGE_W-1:0]};

        unique case (mirror)
            MIR_ONE_LOW:  nt_page = 1'b0;
            MIR_ONE_HIGH: nt_page = 1'b1;
            MIR_VERT:     nt_page = ppu_low[NT_OFF_W-1];
            default:      nt_page = ppu_low[NT_OFF_W];
        endcase
        nt_offset = {nt_page, ppu_low[NT_OFF_W-2:0]};
    end

endmodule

// File: rtl/serial_bank_mapper.sv
module serial_bank_mapper
    import mapper_pkg::*;
#(
    parameter int SHIFT_W     = 5,
    localparam int CNT_W      = $clog2(SHIFT_W + 1),
    localparam int ROM_OFF_W  = SHIFT_W + PRG_PAGE_W,
    localparam int CHR_OFF_W  = SHIFT_W + CHR_PAGE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [CPU_AW-1:0]     cpu_addr,
    input  logic [7:0]            wr_data,
    input  logic [SHIFT_W:0]      prg_bank_count,
    input  logic [PPU_AW-1:0]     ppu_addr,
    output logic [SHIFT_W-1:0]    prg_bank_lo,
    output logic [SHIFT_W-1:0]    prg_bank_hi,
    output logic [SHIFT_W-1:0]    chr_bank_lo,
    output logic [SHIFT_W-1:0]    chr_bank_hi,
    output logic [1:0]            mirror_mode,
    output logic [ROM_OFF_W-1:0]  rom_offset,
    output logic [CHR_OFF_W-1:0]  chr_offset,
    output logic [NT_OFF_W-1:0]   nt_offset
);
    typedef struct packed {
        logic [SHIFT_W-1:0] shift;
        logic [CNT_W-1:0]   count;
        logic [SHIFT_W-1:0] ctrl;
        logic [SHIFT_W-1:0] chr0;
        logic [SHIFT_W-1:0] chr1;
        logic [SHIFT_W-1:0] prg;
        logic [SHIFT_W-1:0] win_prg_lo;
        logic [SHIFT_W-1:0] win_prg_hi;
        logic [SHIFT_W-1:0] win_chr_lo;
        logic [SHIFT_W-1:0] win_chr_hi;
        mirror_e            win_mirror;
    } state_t;

    localparam logic [SHIFT_W-1:0] CTRL_RESET =
        SHIFT_W'(2'b11) << CTRL_LAYOUT_LO;

    state_t state_d, state_q;

    logic               wr_fire;
    logic [SHIFT_W-1:0] ld_shift_d;
    logic [CNT_W-1:0]   ld_count_d;
    logic               ld_commit;
    logic               ld_reset;
    logic [SHIFT_W-1:0] ld_value;

    logic [SHIFT_W:0]   last_full;
    logic [SHIFT_W-1:0] calc_prg_lo, calc_prg_hi, calc_chr_lo, calc_chr_hi;
    mirror_e            calc_mirror;

    logic               unused_inputs;

    assign wr_fire       = wr_en & cpu_addr[CPU_AW-1];
    assign last_full     = prg_bank_count - (SHIFT_W+1)'(1);
    assign unused_inputs = ^{wr_data[6:1], last_full[SHIFT_W], ppu_addr[PPU_AW-1]};

    mapper_serial_loader #(.SHIFT_W(SHIFT_W)) u_loader (
        .wr_fire      (wr_fire),
        .reset_bit    (wr_data[7]),
        .data_bit     (wr_data[0]),
        .shift_q      (state_q.shift),
        .count_q      (state_q.count),
        .shift_d      (ld_shift_d),
        .count_d      (ld_count_d),
        .commit       (ld_commit),
        .loader_reset (ld_reset),
        .commit_val   (ld_value)
    );

    mapper_bank_calc #(.SHIFT_W(SHIFT_W)) u_calc (
        .ctrl      (state_q.ctrl),
        .chr0      (state_q.chr0),
        .chr1      (state_q.chr1),
        .prg       (state_q.prg),
        .last_bank (last_full[SHIFT_W-1:0]),
        .prg_lo    (calc_prg_lo),
        .prg_hi    (calc_prg_hi),
        .chr_lo    (calc_chr_lo),
        .chr_hi    (calc_chr_hi),
        .mirror    (calc_mirror)
    );

    mapper_addr_xlate #(.SHIFT_W(SHIFT_W)) u_xlate (
        .cpu_low    (cpu_addr[PRG_PAGE_W:0]),
        .ppu_low    (ppu_addr[PPU_AW-2:0]),
        .prg_lo     (state_q.win_prg_lo),
        .prg_hi     (state_q.win_prg_hi),
        .chr_lo     (state_q.win_chr_lo),
        .chr_hi     (state_q.win_chr_hi),
        .mirror     (state_q.win_mirror),
        .rom_offset (rom_offset),
        .chr_offset (chr_offset),
        .nt_offset  (nt_offset)
    );

    always_comb begin
        state_d       = state_q;
        state_d.shift = ld_shift_d;
        state_d.count = ld_count_d;

        if (ld_reset) begin
            state_d.ctrl = state_q.ctrl | CTRL_RESET;
        end

        if (ld_commit) begin
            unique case (target_e'(cpu_addr[PRG_PAGE_W:PRG_PAGE_W-1]))
                TGT_CTRL: state_d.ctrl = ld_value;
                TGT_CHR0: state_d.chr0 = ld_value;
                TGT_CHR1: state_d.chr1 = ld_value;
                default:  state_d.prg  = ld_value;
            endcase
        end

        // Window stage follows the registers one edge later
        state_d.win_prg_lo = calc_prg_lo;
        state_d.win_prg_hi = calc_prg_hi;
        state_d.win_chr_lo = calc_chr_lo;
        state_d.win_chr_hi = calc_chr_hi;
        state_d.win_mirror = calc_mirror;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q            <= '0;
            state_q.count      <= CNT_W'(SHIFT_W);
            state_q.ctrl       <= CTRL_RESET;
            state_q.win_mirror <= MIR_ONE_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    assign prg_bank_lo = state_q.win_prg_lo;
    assign prg_bank_hi = state_q.win_prg_hi;
    assign chr_bank_lo = state_q.win_chr_lo;
    assign chr_bank_hi = state_q.win_chr_hi;
    assign mirror_mode = state_q.win_mirror;

endmodule

// File: rtl/mapper_checker.sv
module mapper_checker #(
    parameter int SHIFT_W = 5,
    localparam int CNT_W  = $clog2(SHIFT_W + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic               addr_top,
    input logic               reset_bit,
    input logic [CNT_W-1:0]   count,
    input logic [SHIFT_W-1:0] ctrl,
    input logic [SHIFT_W-1:0] prg_lo,
    input logic [SHIFT_W-1:0] prg_hi,
    input logic [SHIFT_W-1:0] chr_lo,
    input logic [SHIFT_W-1:0] chr_hi,
    input logic [13:0]        cpu_page,
    input logic [13:0]        rom_page,
    input logic [11:0]        ppu_page,
    input logic [11:0]        chr_page
);
    p_reset_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr_top && reset_bit)
        |=> (count == CNT_W'(SHIFT_W) && ctrl[3:2] == 2'b11));

    p_ignore_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr_top) |=> ($stable(count) && $stable(ctrl)));

    p_count_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (count >= CNT_W'(1) && count <= CNT_W'(SHIFT_W)));

    p_prg_fixed_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[3:2] == 2'b10) |=> (prg_lo == '0));

    p_prg_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[3] == 1'b0) |=> (prg_lo[0] == 1'b0 && prg_hi == (prg_lo | SHIFT_W'(1))));

    p_chr_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[4] == 1'b0) |=> (chr_lo[0] == 1'b0 && chr_hi == (chr_lo | SHIFT_W'(1))));

    p_rom_page_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rom_page == cpu_page);

    p_chr_page_r10: assert property (@(posedge clk) disable iff (!rst_n)
        chr_page == ppu_page);

endmodule

bind serial_bank_mapper mapper_checker #(.SHIFT_W(SHIFT_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr_top  (cpu_addr[15]),
    .reset_bit (wr_data[7]),
    .count     (state_q.count),
    .ctrl      (state_q.ctrl),
    .prg_lo    (prg_bank_lo),
    .prg_hi    (prg_bank_hi),
    .chr_lo    (chr_bank_lo),
    .chr_hi    (chr_bank_hi),
    .cpu_page  (cpu_addr[13:0]),
    .rom_page  (rom_offset[13:0]),
    .ppu_page  (ppu_addr[11:0]),
    .chr_page  (chr_offset[11:0])
);

// File: tb/serial_bank_mapper_tb.sv
module serial_bank_mapper_tb;
    localparam int SW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [15:0]   cpu_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [SW:0]   prg_bank_count = 6'd8;
    logic [13:0]   ppu_addr = '0;
    logic [SW-1:0] prg_bank_lo, prg_bank_hi, chr_bank_lo, chr_bank_hi;
    logic [1:0]    mirror_mode;
    logic [SW+13:0] rom_offset;
    logic [SW+11:0] chr_offset;
    logic [10:0]   nt_offset;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Bench reference state
    logic [4:0] m_ctrl, m_chr0, m_chr1, m_prg, m_shift;
    int         m_cnt;

    always #10 clk = ~clk;

    serial_bank_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cpu_addr(cpu_addr),
        .wr_data(wr_data), .prg_bank_count(prg_bank_count), .ppu_addr(ppu_addr),
        .prg_bank_lo(prg_bank_lo), .prg_bank_hi(prg_bank_hi),
        .chr_bank_lo(chr_bank_lo), .chr_bank_hi(chr_bank_hi),
        .mirror_mode(mirror_mode), .rom_offset(rom_offset),
        .chr_offset(chr_offset), .nt_offset(nt_offset)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] e_prg_lo();
        case (m_ctrl[3:2])
            2'd2:    return 5'd0;
            2'd3:    return m_prg;
            default: return {m_prg[4:1], 1'b0};
        endcase
    endfunction

    function automatic logic [4:0] e_prg_hi();
        logic [5:0] last;
        last = prg_bank_count - 6'd1;
        case (m_ctrl[3:2])
            2'd2:    return m_prg;
            2'd3:    return last[4:0];
            default: return {m_prg[4:1], 1'b1};
        endcase
    endfunction

    function automatic logic [4:0] e_chr_lo();
        return m_ctrl[4] ? m_chr0 : {m_chr0[4:1], 1'b0};
    endfunction

    function automatic logic [4:0] e_chr_hi();
        return m_ctrl[4] ? m_chr1 : {m_chr0[4:1], 1'b1};
    endfunction

    function automatic logic [10:0] e_nt(input logic [13:0] a);
        case (m_ctrl[1:0])
            2'd0:    return {1'b0, a[9:0]};
            2'd1:    return {1'b1, a[9:0]};
            2'd2:    return a[10:0];
            default: return {a[11], a[9:0]};
        endcase
    endfunction

    task automatic model_reset();
        m_ctrl = 5'h0C; m_chr0 = '0; m_chr1 = '0; m_prg = '0;
        m_shift = '0; m_cnt = 5;
    endtask

    // One bus write; called and returns at a falling edge
    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d, input bit en = 1'b1);
        cpu_addr = a; wr_data = d; wr_en = en;
        if (en && a[15]) begin
            if (d[7]) begin
                m_shift = '0; m_cnt = 5; m_ctrl[3:2] = 2'b11;
            end else begin
                m_shift = {d[0], m_shift[4:1]};
                m_cnt--;
                if (m_cnt == 0) begin
                    case (a[14:13])
                        2'd0: m_ctrl = m_shift;
                        2'd1: m_chr0 = m_shift;
                        2'd2: m_chr1 = m_shift;
                        default: m_prg = m_shift;
                    endcase
                    m_shift = '0; m_cnt = 5;
                end
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_reg(input logic [1:0] tgt, input logic [4:0] v);
        for (int i = 0; i < 5; i++)
            bus_wr({1'b1, tgt, 13'h0123}, {7'h2A & 7'h7E, v[i]} & 8'h7F);
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic check_windows(input string req);
        chk(prg_bank_lo == e_prg_lo(), {req, " prg_lo"}, prg_bank_lo, e_prg_lo());
        chk(prg_bank_hi == e_prg_hi(), {req, " prg_hi"}, prg_bank_hi, e_prg_hi());
        chk(chr_bank_lo == e_chr_lo(), {req, " chr_lo"}, chr_bank_lo, e_chr_lo());
        chk(chr_bank_hi == e_chr_hi(), {req, " chr_hi"}, chr_bank_hi, e_chr_hi());
        chk(mirror_mode == m_ctrl[1:0], {req, " mirror"}, mirror_mode, m_ctrl[1:0]);
    endtask

    task automatic check_offsets(input logic [15:0] ca, input logic [13:0] pa);
        logic [SW+13:0] er;
        logic [SW+11:0] ec;
        cpu_addr = ca; ppu_addr = pa;
        #1;
        er = {(ca[14] ? e_prg_hi() : e_prg_lo()), ca[13:0]};
        ec = {(pa[12] ? e_chr_hi() : e_chr_lo()), pa[11:0]};
        chk(rom_offset == er, "R9 rom_offset", rom_offset, er);
        chk(chr_offset == ec, "R10 chr_offset", chr_offset, ec);
        chk(nt_offset == e_nt(pa), "R6 nt_offset", nt_offset, e_nt(pa));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [4:0] seed_val;
        seed_val = 5'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R1: reset state, last bank = count-1 = 7
        check_windows("R1");
        check_offsets(16'hC005, 14'h1ABC);

        // R5 / R6: control = 0x02 (vertical, pair layout); windows lag one edge
        load_reg(2'd0, 5'h02);
        chk(mirror_mode == 2'd0, "R5 window unchanged on commit edge", mirror_mode, 0);
        chk(prg_bank_hi == 5'd7, "R5 prg_hi unchanged on commit edge", prg_bank_hi, 7);
        settle();
        check_windows("R5");

        // R6: all four mirroring modes
        for (int m = 0; m < 4; m++) begin
            load_reg(2'd0, {3'b000, 2'(m)});
            settle();
            chk(mirror_mode == 2'(m), "R6 mirror", mirror_mode, m);
            check_offsets(16'h8000, 14'h2805);
            check_offsets(16'h8000, 14'h2C05);
            check_offsets(16'h8000, 14'h2413);
        end

        // R8: program layouts with program bank 11, 16 banks
        prg_bank_count = 6'd16;
        load_reg(2'd3, 5'd11);
        for (int l = 0; l < 4; l++) begin
            load_reg(2'd0, {1'b0, 2'(l), 2'b00});
            settle();
            check_windows("R8");
            check_offsets(16'hC123, 14'h0040);
            check_offsets(16'h8123, 14'h0040);
        end

        // R7: character modes
        load_reg(2'd1, 5'd9);
        load_reg(2'd2, 5'd20);
        load_reg(2'd0, 5'h0C);
        settle();
        check_windows("R7 paired");
        check_offsets(16'h8000, 14'h1FFF);
        load_reg(2'd0, 5'h1C);
        settle();
        check_windows("R7 split");
        chk(chr_bank_hi == 5'd20, "R7 chr_hi bank1", chr_bank_hi, 20);
        check_offsets(16'h8000, 14'h1FFF);
        check_offsets(16'h8000, 14'h0FFF);

        // R3: reset bit abandons partial value and forces layout 3
        load_reg(2'd0, 5'h11);              // layout 0, mirror 1, split on
        bus_wr(16'hE000, 8'h01);
        bus_wr(16'hE000, 8'h01);
        bus_wr(16'hE000, 8'h00);
        bus_wr(16'h8000, 8'h80);
        settle();
        check_windows("R3 forced layout");
        chk(mirror_mode == 2'd1, "R3 mirror kept", mirror_mode, 1);
        load_reg(2'd3, 5'd6);
        settle();
        chk(prg_bank_lo == 5'd6, "R3 fresh value after reset bit", prg_bank_lo, 6);
        check_windows("R3");

        // R2: ignored writes interleaved in a sequence
        bus_wr(16'hE000, 8'h01);            // bit0 = 1
        bus_wr(16'h6000, 8'h00);            // lower half, ignored
        bus_wr(16'hE000, 8'h00, 1'b0);      // strobe low, ignored
        bus_wr(16'h7FFF, 8'h80);            // lower half reset bit, ignored
        bus_wr(16'hE000, 8'h01);            // bit1 = 1
        bus_wr(16'hE000, 8'h00);
        bus_wr(16'h2000, 8'h01);            // ignored
        bus_wr(16'hE000, 8'h01);            // bit3 = 1
        bus_wr(16'hE000, 8'h00);            // commit 0b01011 = 11
        settle();
        chk(prg_bank_lo == 5'd11, "R2 ignored writes", prg_bank_lo, 11);

        // R4: bit order and target select, directed
        load_reg(2'd0, 5'h1F);
        load_reg(2'd1, 5'b00001);
        load_reg(2'd2, 5'b10000);
        settle();
        chk(chr_bank_lo == 5'd1, "R4 first write is bit 0", chr_bank_lo, 1);
        chk(chr_bank_hi == 5'd16, "R4 fifth write is bit 4", chr_bank_hi, 16);
        check_windows("R4");

        // Random mix
        for (int it = 0; it < 250; it++) begin
            logic [1:0] tgt;
            logic [4:0] v;
            tgt = 2'($urandom());
            v   = 5'($urandom()) ^ seed_val;
            if ($urandom_range(0, 9) == 0) bus_wr(16'($urandom()) & 16'h7FFF, 8'($urandom()));
            if ($urandom_range(0, 7) == 0) begin
                bus_wr(16'h8000 | 16'($urandom()), 8'h00);
                bus_wr(16'h8000 | 16'($urandom()), 8'h80);
            end
            if ($urandom_range(0, 15) == 0) prg_bank_count = 6'($urandom_range(1, 32));
            load_reg(tgt, v);
            settle();
            check_windows("R4 random");
            check_offsets(16'($urandom()), 14'($urandom()));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule